// File: doc/BRIEF.md
# Generic Clock Generator and Channel Controller

This block holds a bank of clock generators and a bank of peripheral clock channels. Software sets them up through a small 32-bit register bus that uses word addresses. Each generator picks one source from a set of clock-enable inputs, divides it by a linear or power-of-two ratio, and can be switched on or off on its own. Each channel picks the generator that feeds it and has its own enable bit and a write-lock bit that stays set once it is set.

All clocks are modelled as one-cycle enable pulses in the single system clock domain. Each generator output is a register that toggles at the divided rate. Each generator also gives a tick: a one-cycle pulse on each rising edge of its output. Generator 1 is the only generator that other generators can use as a source. Generator 0 also drives the main clock output. A self-clearing software reset returns the registers to their defaults. It leaves write-locked channels alone, and it leaves the generators those channels point to alone.

Top module: `gclk_ctrl`

## Requirements
- R1: After hardware reset, generator 0 reads 0x00000011 (enabled, source code 1, undivided), and every other generator and channel reads 0. The main clock output then has a period of 2 cycles while src_tick[0] is held high.
- R2: With the divide-mode bit at 0, the output toggles once every DIV source ticks, so the period is 2*DIV ticks. DIV values 0 and 1 both give a period of 2 ticks.
- R3: With the divide-mode bit at 1, the period is 2^(DIV+1) source ticks. The exponent DIV is capped at CNT_W-1, which is 15 by default.
- R4: When a generator is disabled, its output goes low in the next cycle and stays low, and it gives no ticks.
- R5: Source codes select as follows. Code 0 is the generator's own pin_in bit, and it counts only while the pin-direction bit is 0. Codes 1 to 7 select src_tick[code-1]. Code 8 selects the ticks of generator 1, on every generator except generator 1. Codes 9 to 15 give no ticks.
- R6: Generator 1 has eight source codes. Writing a source code above 7 to generator 1 stores 0.
- R7: pin_oe[g] follows the pin-direction bit (bit 2) of generator g. pin_out[g] always carries the output of generator g.
- R8: A channel's ch_clk and ch_tick follow its selected generator only when the channel is enabled and that generator is enabled. A generator number of NUM_GEN or more gives a channel that stays low.
- R9: Any write to a channel whose lock bit is set is ignored. The lock bit is cleared only by hardware reset.
- R10: Writing 1 to bit 0 at address 0x00 starts a software reset. STATUS (address 0x01) bit 0 and address 0x00 bit 0 read 1 until the next clock edge. At that edge the reset is applied and the bit clears.
- R11: The software reset returns every generator and channel to its hardware-reset value. It spares channels whose lock bit is set, and it spares every generator that such a channel selects.
- R12: The tick of a generator is a one-cycle pulse on each rising edge of that generator's output. main_clk and main_tick carry the output and tick of generator 0.
- R13: Register layout. Generator g sits at address 0x10+g, with enable [0], divide mode [1], pin direction [2], source [7:4] and DIV [23:16]. Channel m sits at address 0x20+m, with enable [0], lock [1] and generator [11:8]. Reads return the stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low hardware reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_tick | input | NUM_EXT | Shared source clock-enable pulses |
| pin_in | input | NUM_GEN | Per-generator pin input pulses |
| pin_out | output | NUM_GEN | Per-generator pin output value |
| pin_oe | output | NUM_GEN | Per-generator pin output enable |
| main_clk | output | 1 | Generator 0 output |
| main_tick | output | 1 | Generator 0 tick |
| ch_clk | output | NUM_CH | Channel clock outputs |
| ch_tick | output | NUM_CH | Channel tick outputs |

## Verification
The hardest case to reach is a software reset that must sort state into two groups. Part of it has to survive: a locked channel and the generator it selects, which in turn cascades from generator 1. The rest has to be cleared: an unlocked channel, an unrelated generator with its pin driving out, and generator 1 itself. The bench builds that whole arrangement through ordinary register writes. It locks one channel partway through, fires the reset, reads the busy flag before the next clock edge, and then reads back every register. The 2^15 exponent cap is reached by programming an oversize exponent and watching for the first rising edge near 32768 cycles.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
    localparam int ADDR_W  = 6;
    localparam int SRC_W   = 4;
    localparam int DIV_W   = 8;
    localparam int SEL_W   = 4;
    localparam int GEN_BASE = 16;
    localparam int CH_BASE  = 32;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] A_STATUS = 6'h01;

    localparam int F_SRC = 4;
    localparam int F_DIV = 16;
    localparam int F_SEL = 8;

    typedef struct packed {
        logic             en;
        logic             divsel;
        logic             oe;
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } gen_cfg_t;

    typedef struct packed {
        logic             en;
        logic             lock;
        logic [SEL_W-1:0] gen;
    } ch_cfg_t;

    function automatic gen_cfg_t gen_from_word(logic [31:0] w);
        gen_cfg_t c;
        c.en     = w[0];
        c.divsel = w[1];
        c.oe     = w[2];
        c.src    = w[F_SRC +: SRC_W];
        c.div    = w[F_DIV +: DIV_W];
        return c;
    endfunction

    function automatic logic [31:0] gen_to_word(gen_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.divsel;
        w[2] = c.oe;
        w[F_SRC +: SRC_W] = c.src;
        w[F_DIV +: DIV_W] = c.div;
        return w;
    endfunction

    function automatic ch_cfg_t ch_from_word(logic [31:0] w);
        ch_cfg_t c;
        c.en   = w[0];
        c.lock = w[1];
        c.gen  = w[F_SEL +: SEL_W];
        return c;
    endfunction

    function automatic logic [31:0] ch_to_word(ch_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[0] = c.en;
        w[1] = c.lock;
        w[F_SEL +: SEL_W] = c.gen;
        return w;
    endfunction

    function automatic gen_cfg_t gen_default(int idx);
        gen_cfg_t c;
        c = '0;
        if (idx == 0) begin
            c.en  = 1'b1;
            c.src = SRC_W'(1);
        end
        return c;
    endfunction
endpackage

// File: rtl/gclk_regs.sv
module gclk_regs
    import gclk_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int NUM_CH  = 6,
    parameter int NUM_EXT = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [31:0]               wdata,
    output logic [31:0]               rdata,
    output gen_cfg_t [NUM_GEN-1:0]    gen_cfg,
    output ch_cfg_t  [NUM_CH-1:0]     ch_cfg,
    output logic                      busy
);
    typedef struct packed {
        gen_cfg_t [NUM_GEN-1:0] gen;
        ch_cfg_t  [NUM_CH-1:0]  ch;
        logic                   busy;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [NUM_GEN-1:0] keep_gen;
    gen_cfg_t wr_gen;

    always_comb begin
        keep_gen = '0;
        for (int m = 0; m < NUM_CH; m++) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (regs_q.ch[m].lock && int'(regs_q.ch[m].gen) == g)
                    keep_gen[g] = 1'b1;
            end
        end
    end

    always_comb begin
        regs_d = regs_q;
        wr_gen = gen_from_word(wdata);
        if (regs_q.busy) begin
            for (int g = 0; g < NUM_GEN; g++) begin
                if (!keep_gen[g]) regs_d.gen[g] = gen_default(g);
            end
            for (int m = 0; m < NUM_CH; m++) begin
                if (!regs_q.ch[m].lock) regs_d.ch[m] = '0;
            end
            regs_d.busy = 1'b0;
        end else if (wr) begin
            if (addr == A_CTRL && wdata[0]) regs_d.busy = 1'b1;
            for (int g = 0; g < NUM_GEN; g++) begin
                if (addr == ADDR_W'(GEN_BASE + g)) begin
                    regs_d.gen[g] = wr_gen;
                    if (g == 1 && int'(wr_gen.src) > NUM_EXT)
                        regs_d.gen[g].src = '0;
                end
            end
            for (int m = 0; m < NUM_CH; m++) begin
                if (addr == ADDR_W'(CH_BASE + m) && !regs_q.ch[m].lock)
                    regs_d.ch[m] = ch_from_word(wdata);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GEN; g++) regs_q.gen[g] <= gen_default(g);
            regs_q.ch   <= '0;
            regs_q.busy <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL || addr == A_STATUS) rdata[0] = regs_q.busy;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (addr == ADDR_W'(GEN_BASE + g)) rdata = gen_to_word(regs_q.gen[g]);
        end
        for (int m = 0; m < NUM_CH; m++) begin
            if (addr == ADDR_W'(CH_BASE + m)) rdata = ch_to_word(regs_q.ch[m]);
        end
    end

    assign gen_cfg = regs_q.gen;
    assign ch_cfg  = regs_q.ch;
    assign busy    = regs_q.busy;
endmodule

// File: rtl/gclk_div.sv
module gclk_div
    import gclk_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             divsel,
    input  logic [DIV_W-1:0] div,
    input  logic             src_tick,
    output logic             clk_out,
    output logic             tick_out
);
    localparam int EXP_MAX = CNT_W - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             out;
        logic             tick;
    } div_t;

    div_t st_d, st_q;
    logic [CNT_W-1:0] half;
    int exp_v;

    always_comb begin
        exp_v = (int'(div) > EXP_MAX) ? EXP_MAX : int'(div);
        if (divsel) half = CNT_W'(1) << exp_v;
        else if (div == '0) half = CNT_W'(1);
        else half = CNT_W'(div);
    end

    always_comb begin
        st_d = st_q;
        st_d.tick = 1'b0;
        if (!en) begin
            st_d.cnt = '0;
            st_d.out = 1'b0;
        end else if (src_tick) begin
            if (st_q.cnt >= half - CNT_W'(1)) begin
                st_d.cnt  = '0;
                st_d.out  = ~st_q.out;
                st_d.tick = ~st_q.out;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_out  = st_q.out;
    assign tick_out = st_q.tick;
endmodule

// File: rtl/gclk_chan.sv
module gclk_chan
    import gclk_pkg::*;
#(
    parameter int NUM_GEN = 4
) (
    input  ch_cfg_t            cfg,
    input  logic [NUM_GEN-1:0] gen_en,
    input  logic [NUM_GEN-1:0] gen_out,
    input  logic [NUM_GEN-1:0] gen_tick,
    output logic               clk_o,
    output logic               tick_o
);
    always_comb begin
        clk_o  = 1'b0;
        tick_o = 1'b0;
        for (int g = 0; g < NUM_GEN; g++) begin
            if (cfg.en && int'(cfg.gen) == g && gen_en[g]) begin
                clk_o  = gen_out[g];
                tick_o = gen_tick[g];
            end
        end
    end

    logic unused_lock;
    assign unused_lock = cfg.lock;
endmodule

// File: rtl/gclk_ctrl.sv
module gclk_ctrl
    import gclk_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int NUM_CH  = 6,
    parameter int NUM_EXT = 7,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [5:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_EXT-1:0] src_tick,
    input  logic [NUM_GEN-1:0] pin_in,
    output logic [NUM_GEN-1:0] pin_out,
    output logic [NUM_GEN-1:0] pin_oe,
    output logic               main_clk,
    output logic               main_tick,
    output logic [NUM_CH-1:0]  ch_clk,
    output logic [NUM_CH-1:0]  ch_tick
);
    localparam int CASCADE_CODE = NUM_EXT + 1;
    localparam int CASCADE_GEN  = 1;

    gen_cfg_t [NUM_GEN-1:0] gen_cfg;
    ch_cfg_t  [NUM_CH-1:0]  ch_cfg;
    logic                   swrst_busy;
    logic [NUM_GEN-1:0]     gen_en;
    logic [NUM_GEN-1:0]     gen_out;
    logic [NUM_GEN-1:0]     gen_tick;
    logic [NUM_GEN-1:0]     sel_tick;

    gclk_regs #(.NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .gen_cfg (gen_cfg),
        .ch_cfg  (ch_cfg),
        .busy    (swrst_busy)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        always_comb begin
            sel_tick[g] = 1'b0;
            if (gen_cfg[g].src == '0) sel_tick[g] = pin_in[g] & ~gen_cfg[g].oe;
            for (int k = 0; k < NUM_EXT; k++) begin
                if (int'(gen_cfg[g].src) == k + 1) sel_tick[g] = src_tick[k];
            end
            if (g != CASCADE_GEN && int'(gen_cfg[g].src) == CASCADE_CODE)
                sel_tick[g] = gen_tick[CASCADE_GEN];
        end

        assign gen_en[g] = gen_cfg[g].en;
        assign pin_oe[g] = gen_cfg[g].oe;

        gclk_div #(.CNT_W(CNT_W)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (gen_cfg[g].en),
            .divsel   (gen_cfg[g].divsel),
            .div      (gen_cfg[g].div),
            .src_tick (sel_tick[g]),
            .clk_out  (gen_out[g]),
            .tick_out (gen_tick[g])
        );
    end

    for (genvar m = 0; m < NUM_CH; m++) begin : g_ch
        gclk_chan #(.NUM_GEN(NUM_GEN)) u_chan (
            .cfg      (ch_cfg[m]),
            .gen_en   (gen_en),
            .gen_out  (gen_out),
            .gen_tick (gen_tick),
            .clk_o    (ch_clk[m]),
            .tick_o   (ch_tick[m])
        );
    end

    assign pin_out   = gen_out;
    assign main_clk  = gen_out[0];
    assign main_tick = gen_tick[0];
endmodule

// File: rtl/gclk_ctrl_chk.sv
module gclk_ctrl_chk
    import gclk_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int NUM_CH  = 6,
    parameter int NUM_EXT = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  busy,
    input logic [NUM_GEN-1:0]    gen_en,
    input logic [NUM_GEN-1:0]    gen_out,
    input logic [NUM_GEN-1:0]    gen_tick,
    input ch_cfg_t [NUM_CH-1:0]  ch_cfg,
    input logic [SRC_W-1:0]      gen1_src
);
    // R10
    swrst_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R6
    gen1_src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(gen1_src) <= NUM_EXT);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen_chk
        // R4
        disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en[g] |=> !gen_out[g]);
        // R12
        tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_tick[g] |=> !gen_tick[g]);
        // R12
        tick_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_tick[g] |-> gen_out[g]);
    end

    for (genvar m = 0; m < NUM_CH; m++) begin : g_ch_chk
        // R9
        lock_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_cfg[m].lock |=> $stable(ch_cfg[m]));
    end
endmodule

bind gclk_ctrl gclk_ctrl_chk #(.NUM_GEN(NUM_GEN), .NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (swrst_busy),
    .gen_en   (gen_en),
    .gen_out  (gen_out),
    .gen_tick (gen_tick),
    .ch_cfg   (ch_cfg),
    .gen1_src (gen_cfg[1].src)
);

// File: tb/gclk_ctrl_tb.sv
`timescale 1ns/1ps
module gclk_ctrl_tb;
    localparam int NG = 4;
    localparam int NC = 6;
    localparam int NE = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [5:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NE-1:0] src_tick = '1;
    logic [NG-1:0] pin_in = '0;
    logic [NG-1:0] pin_out, pin_oe;
    logic          main_clk, main_tick;
    logic [NC-1:0] ch_clk, ch_tick;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    gclk_ctrl #(.NUM_GEN(NG), .NUM_CH(NC), .NUM_EXT(NE)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .main_clk(main_clk), .main_tick(main_tick), .ch_clk(ch_clk), .ch_tick(ch_tick)
    );

    function automatic logic [31:0] gw(bit en, bit ds, bit oe, int src, int div);
        return {8'h0, 8'(div), 8'h0, 4'(src), 1'b0, oe, ds, en};
    endfunction

    function automatic logic [31:0] cw(bit en, bit lk, int gen);
        return {20'h0, 4'(gen), 6'h0, lk, en};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_now(int a, output int d);
        bus_addr = 6'(a);
        #0.5;
        d = int'(bus_rdata);
    endtask

    task automatic rd(int a, output int d);
        @(negedge clk);
        rd_now(a, d);
    endtask

    function automatic bit sig(int s);
        if (s == 200) return main_clk;
        if (s >= 100) return ch_clk[s-100];
        return pin_out[s];
    endfunction

    task automatic count_rises(int s, int n, output int r);
        bit prev;
        @(negedge clk);
        prev = sig(s);
        r = 0;
        repeat (n) begin
            @(negedge clk);
            if (sig(s) && !prev) r++;
            prev = sig(s);
        end
    endtask

    task automatic period(int s, output int p);
        bit prev;
        int t;
        p = -1;
        t = 0;
        @(negedge clk);
        prev = sig(s);
        while (t < 400 && !(sig(s) && !prev)) begin
            prev = sig(s); @(negedge clk); t++;
        end
        if (t >= 400) return;
        prev = sig(s);
        t = 0;
        do begin
            @(negedge clk); t++;
            if (sig(s) && !prev) begin p = t; return; end
            prev = sig(s);
        end while (t < 400);
    endtask

    task automatic t_reset();
        int d, n;
        rd(16, d); check("R1 gen0 reset word", d, 32'h11);
        rd(18, d); check("R1 gen2 reset word", d, 0);
        rd(32, d); check("R1 ch0 reset word", d, 0);
        rd(1, d);  check("R10 status idle", d, 0);
        period(200, d); check("R1 main clock period", d, 2);
        n = 0;
        repeat (20) begin @(negedge clk); if (main_tick) n++; end
        check("R12 main tick count over 20 cycles", n, 10);
    endtask

    task automatic t_linear();
        int p, d;
        wr(18, gw(1,0,0,1,3)); period(2, p); check("R2 div 3 period", p, 6);
        rd(18, d); check("R13 gen2 readback", d, 32'h0003_0011);
        wr(18, gw(1,0,0,1,0)); period(2, p); check("R2 div 0 period", p, 2);
        wr(18, gw(1,0,0,1,1)); period(2, p); check("R2 div 1 period", p, 2);
        wr(18, gw(1,0,0,1,5)); period(2, p); check("R2 div 5 period", p, 10);
    endtask

    task automatic t_pow2();
        int p, r;
        wr(18, gw(1,1,0,1,2)); period(2, p); check("R3 pow2 div 2 period", p, 8);
        wr(18, gw(1,1,0,1,0)); period(2, p); check("R3 pow2 div 0 period", p, 2);
        wr(19, gw(1,1,0,1,20));
        count_rises(3, 32000, r); check("R3 capped: no edge before 32000", r, 0);
        count_rises(3, 1600, r);  check("R3 capped: edge near 32768", r, 1);
        wr(19, 0);
    endtask

    task automatic t_disable();
        int r;
        wr(18, gw(0,0,0,1,1));
        count_rises(2, 40, r); check("R4 disabled gen rises", r, 0);
        check("R4 disabled gen output level", int'(pin_out[2]), 0);
    endtask

    task automatic t_source();
        int p, r;
        pin_in[3] = 1'b1;
        wr(19, gw(1,0,0,0,1)); period(3, p); check("R5 pin source period", p, 2);
        wr(19, gw(1,0,1,0,1));
        check("R7 pin_oe follows direction bit", int'(pin_oe[3]), 1);
        count_rises(3, 40, r); check("R5 pin source off while output", r, 0);
        wr(19, gw(1,0,0,9,1)); count_rises(3, 40, r); check("R5 code 9 gives no ticks", r, 0);
        src_tick[3] = 1'b0;
        wr(19, gw(1,0,0,4,1)); count_rises(3, 40, r); check("R5 code 4 idle source", r, 0);
        src_tick[3] = 1'b1;
        period(3, p); check("R5 code 4 source resumes", p, 2);
        pin_in[3] = 1'b0;
        wr(19, 0);
        check("R7 pin_oe cleared", int'(pin_oe[3]), 0);
    endtask

    task automatic t_gen1();
        int d, p;
        wr(17, gw(1,0,0,8,0)); rd(17, d); check("R6 gen1 code 8 stored as 0", d, 32'h01);
        wr(17, gw(1,0,0,1,0));
        wr(18, gw(1,0,0,8,2)); period(2, p); check("R5 cascade from gen1 period", p, 8);
    endtask

    task automatic t_chan();
        int p, r;
        wr(32, cw(1,0,2)); period(100, p); check("R8 channel follows gen2", p, 8);
        wr(32, cw(0,0,2)); count_rises(100, 40, r); check("R8 disabled channel", r, 0);
        wr(19, 0);
        wr(32, cw(1,0,3)); count_rises(100, 40, r); check("R8 channel on disabled gen", r, 0);
        wr(32, cw(1,0,7)); count_rises(100, 40, r); check("R8 channel out-of-range gen", r, 0);
    endtask

    task automatic t_lock();
        int d, p;
        wr(33, cw(1,1,2));
        wr(33, cw(0,0,0)); rd(33, d); check("R9 locked channel write ignored", d, 32'h203);
        period(101, p); check("R9 locked channel still runs", p, 8);
    endtask

    task automatic t_swrst();
        int d;
        wr(19, gw(1,0,1,1,4));
        wr(32, cw(1,0,2));
        wr(0, 32'h1);
        rd_now(1, d); check("R10 status busy after request", d, 1);
        rd(1, d); check("R10 status cleared", d, 0);
        rd(0, d); check("R10 ctrl bit cleared", d, 0);
        rd(19, d); check("R11 unlocked gen3 reset", d, 0);
        rd(18, d); check("R11 gen2 kept by lock", d, int'(gw(1,0,0,8,2)));
        rd(17, d); check("R11 gen1 reset", d, 0);
        rd(16, d); check("R11 gen0 default", d, 32'h11);
        rd(33, d); check("R11 locked ch1 kept", d, 32'h203);
        rd(32, d); check("R11 unlocked ch0 reset", d, 0);
        check("R7 pin_oe after reset", int'(pin_oe[3]), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_linear();
        t_pow2();
        t_disable();
        t_source();
        t_gen1();
        t_chan();
        t_lock();
        t_swrst();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule